// File: doc/BRIEF.md
# Audio master clock ratio generator

This block derives the three clocks of a serial audio port from one fixed system clock: a master clock for an external converter, a bit clock, and a left/right frame clock. It is configured by a static control word. A 3-bit power-of-two multiplier and a family bit select the master-clock ratio to the sample rate (fs). The family bit chooses between the 512·fs family and the 384·fs family. A separate bit picks a bit clock of 32·fs or 48·fs.

All three clocks come out as single-cycle enables, or as a level for the frame clock, in the system clock domain. Internally a prescaler of `BASE_DIV` system cycles makes one base tick, and one sample frame spans 1536 base ticks. Every legal master-clock ratio and both bit-clock rates divide that frame evenly, so no fractional divider is needed.

The master clock starts as soon as the port is enabled, before any audio data moves, so an external converter can lock early. Illegal ratio codes hold the port silent and raise an error flag.

Top module: `audio_clk_ratio_gen`

## Requirements
- R1: With the family bit clear, multiplier codes 4, 3, 2, 1, 0 give master-clock ratios of 32, 64, 128, 256, 512 ·fs. Consecutive `mclk_pulse_o` pulses are therefore BASE_DIV·3·2^code system cycles apart.
- R2: With the family bit set, multiplier codes 3, 2, 1, 0 give ratios of 48, 96, 192, 384 ·fs. Consecutive pulses are BASE_DIV·4·2^code cycles apart.
- R3: Control word fields are as follows. Multiplier at bits 29:27. Family select at bit 26. 48·fs bit-clock enable at bit 3. Run at bit 0. Clock gate at bit 30. Soft reset at bit 31.
- R4: `bclk_pulse_o` pulses BASE_DIV·32 cycles apart when bit 3 is set (48·fs), and BASE_DIV·48 cycles apart when it is clear (32·fs).
- R5: `lrclk_o` is low for the first half of each frame and high for the second half. Each half lasts half the bit clocks of a frame, which is BASE_DIV·768 cycles.
- R6: After the cycle in which the run bit is applied, the first `mclk_pulse_o` and `bclk_pulse_o` appear together on the second clock edge. No other enable is needed.
- R7: While run is clear, or the gate bit or soft-reset bit is set, all clock outputs are low from the second edge on. This covers the case where one of these is asserted mid-run.
- R8: Family set with code 4, or any code from 5 to 7, raises `cfg_err_o` one edge later and keeps all clock outputs low.
- R9: While reset is asserted and directly after it, all outputs are low.
- R10: While running, `lrclk_o` changes only in a cycle in which `bclk_pulse_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Static control word (fields in R3) |
| mclk_pulse_o | output | 1 | One-cycle enable per master-clock period |
| bclk_pulse_o | output | 1 | One-cycle enable per bit-clock period |
| lrclk_o | output | 1 | Frame clock level, low = first channel slot |
| cfg_err_o | output | 1 | Illegal ratio code applied |

## Verification
The bench sweeps every combination of family bit, multiplier code and bit-clock choice. Over more than a full frame it compares each output cycle by cycle against arithmetic predictions. A wrong shift or family step shows as a mismatched pulse spacing. An off-by-one in a divider wrap shows as drift across the frame. A frame clock tied to the wrong bit index flips at the wrong cycle or does not flip within the frame. The family-set, code-4 combination is an illegal code beside a legal one; a decoder that accepted it would emit pulses with `cfg_err_o` low. Gate, soft reset and run removal are each checked from idle and mid-run, where a divider that was not cleared would leave stray pulses.

// File: rtl/acrg_pkg.sv
package acrg_pkg;
  localparam int CTRL_W      = 32;
  localparam int MULT_W      = 3;
  localparam int FRAME_TICKS = 1536;
  localparam int HALF_FRAME  = FRAME_TICKS / 2;
  localparam int STEP_512    = FRAME_TICKS / 512;
  localparam int STEP_384    = FRAME_TICKS / 384;
  localparam int SLOTS_NARROW = 32;
  localparam int SLOTS_WIDE   = 48;
  localparam int MAX_PERIOD  = 48;
  localparam int DIV_W       = $clog2(MAX_PERIOD + 1);
  localparam int SHIFT_W     = DIV_W + (1 << MULT_W);
  localparam int MAX_LEGAL_CODE = 4;

  // control word field positions
  localparam int POS_SRST = 31;
  localparam int POS_GATE = 30;
  localparam int POS_MHI  = 29;
  localparam int POS_MLO  = 27;
  localparam int POS_FAM  = 26;
  localparam int POS_WIDE = 3;
  localparam int POS_RUN  = 0;

  typedef struct packed {
    logic              srst;
    logic              gate;
    logic [MULT_W-1:0] mult;
    logic              fam384;
    logic              wide;
    logic              run;
  } ctrl_fields_t;

  function automatic ctrl_fields_t split_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_fields_t f;
    f.srst   = w[POS_SRST];
    f.gate   = w[POS_GATE];
    f.mult   = w[POS_MHI:POS_MLO];
    f.fam384 = w[POS_FAM];
    f.wide   = w[POS_WIDE];
    f.run    = w[POS_RUN];
    return f;
  endfunction
endpackage

// File: rtl/acrg_ratio_decode.sv
module acrg_ratio_decode
  import acrg_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic [DIV_W-1:0]  mclk_last,
  output logic [DIV_W-1:0]  bclk_last,
  output logic [DIV_W-1:0]  slot_last,
  output logic [DIV_W-1:0]  slot_half,
  output logic              code_bad,
  output logic              run_ok
);
  ctrl_fields_t        f;
  logic [SHIFT_W-1:0]  period_w;
  logic [DIV_W-1:0]    mclk_period;
  logic [DIV_W-1:0]    slots;

  always_comb begin
    f = split_ctrl(ctrl_word);
    code_bad = (f.mult > MULT_W'(MAX_LEGAL_CODE)) ||
               (f.fam384 && (f.mult == MULT_W'(MAX_LEGAL_CODE)));
    period_w = (f.fam384 ? SHIFT_W'(STEP_384) : SHIFT_W'(STEP_512)) << f.mult;
    mclk_period = period_w[DIV_W-1:0];
    slots = f.wide ? DIV_W'(SLOTS_WIDE) : DIV_W'(SLOTS_NARROW);
    if (code_bad) begin
      mclk_last = '0;
      bclk_last = '0;
      slot_last = '0;
      slot_half = '0;
    end else begin
      mclk_last = mclk_period - DIV_W'(1);
      // bit period in base ticks: frame / slots
      bclk_last = (f.wide ? DIV_W'(FRAME_TICKS / SLOTS_WIDE)
                          : DIV_W'(FRAME_TICKS / SLOTS_NARROW)) - DIV_W'(1);
      slot_last = slots - DIV_W'(1);
      slot_half = slots >> 1;
    end
    run_ok = f.run && !f.gate && !f.srst && !code_bad;
  end
endmodule

// File: rtl/acrg_modcount.sv
module acrg_modcount #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         at_zero,
  output logic         at_last
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      if (cnt >= last) cnt_d = '0;
      else             cnt_d = cnt + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign at_zero = (cnt == '0);
  assign at_last = (cnt >= last);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    cnt <= last); // R1

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R7
endmodule

// File: rtl/audio_clk_ratio_gen.sv
module audio_clk_ratio_gen
  import acrg_pkg::*;
#(
  parameter int BASE_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              mclk_pulse_o,
  output logic              bclk_pulse_o,
  output logic              lrclk_o,
  output logic              cfg_err_o
);
  localparam int PRE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic [DIV_W-1:0] mclk_last, bclk_last, slot_last, slot_half;
  logic             code_bad, run_ok;
  logic             en_q, err_q;
  logic             base_tick;
  logic             pre_zero, pre_lastf;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] m_cnt, b_cnt, s_cnt;
  logic             m_zero, m_lastf, b_zero, b_lastf, s_zero, s_lastf;
  logic             mclk_d, bclk_d, lr_d;
  logic             mclk_q, bclk_q, lr_q;

  acrg_ratio_decode u_decode (
    .ctrl_word (ctrl_word),
    .mclk_last (mclk_last),
    .bclk_last (bclk_last),
    .slot_last (slot_last),
    .slot_half (slot_half),
    .code_bad  (code_bad),
    .run_ok    (run_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      en_q  <= run_ok;
      err_q <= code_bad;
    end
  end

  // base tick prescaler: one base tick per BASE_DIV system cycles
  acrg_modcount #(.W(PRE_W)) u_pre (
    .clk (clk), .rst_n (rst_n), .clr (!en_q), .adv (en_q),
    .last (PRE_W'(BASE_DIV - 1)),
    .cnt (pre_cnt), .at_zero (pre_zero), .at_last (pre_lastf)
  );

  assign base_tick = en_q && pre_zero;

  acrg_modcount #(.W(DIV_W)) u_mdiv (
    .clk (clk), .rst_n (rst_n), .clr (!en_q), .adv (base_tick),
    .last (mclk_last),
    .cnt (m_cnt), .at_zero (m_zero), .at_last (m_lastf)
  );

  acrg_modcount #(.W(DIV_W)) u_bdiv (
    .clk (clk), .rst_n (rst_n), .clr (!en_q), .adv (base_tick),
    .last (bclk_last),
    .cnt (b_cnt), .at_zero (b_zero), .at_last (b_lastf)
  );

  // bit index within the frame, advanced at the end of each bit period
  acrg_modcount #(.W(DIV_W)) u_slot (
    .clk (clk), .rst_n (rst_n), .clr (!en_q), .adv (base_tick && b_lastf),
    .last (slot_last),
    .cnt (s_cnt), .at_zero (s_zero), .at_last (s_lastf)
  );

  always_comb begin
    mclk_d = base_tick && m_zero;
    bclk_d = base_tick && b_zero;
    lr_d   = lr_q;
    if (!en_q)                      lr_d = 1'b0;
    else if (base_tick && b_zero)   lr_d = (s_cnt >= slot_half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      mclk_q <= mclk_d;
      bclk_q <= bclk_d;
      lr_q   <= lr_d;
    end
  end

  assign mclk_pulse_o = mclk_q;
  assign bclk_pulse_o = bclk_q;
  assign lrclk_o      = lr_q;
  assign cfg_err_o    = err_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!mclk_pulse_o && !bclk_pulse_o && !lrclk_o)); // R7

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |=> (!mclk_pulse_o && !bclk_pulse_o)); // R8

  AST_LR_ON_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && !$stable(lrclk_o)) |-> bclk_pulse_o); // R10

  AST_START_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |=> (mclk_pulse_o && bclk_pulse_o && !lrclk_o)); // R6
endmodule

// File: tb/audio_clk_ratio_gen_bench.sv
module audio_clk_ratio_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_DIV   = 1;
  localparam int FRAME      = 1536 * BASE_DIV;
  localparam int WIN        = FRAME + 64;
  localparam int WD_CYCLES  = 190000;

  logic        clk;
  logic        rst_n;
  logic [31:0] ctrl_word;
  logic        mclk_pulse_o, bclk_pulse_o, lrclk_o, cfg_err_o;

  int checks = 0;
  int errors = 0;

  audio_clk_ratio_gen #(.BASE_DIV(BASE_DIV)) u_audio_clk_ratio_gen (
    .clk (clk), .rst_n (rst_n), .ctrl_word (ctrl_word),
    .mclk_pulse_o (mclk_pulse_o), .bclk_pulse_o (bclk_pulse_o),
    .lrclk_o (lrclk_o), .cfg_err_o (cfg_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R3 field positions
  function automatic logic [31:0] word(input bit srst, input bit gate,
      input int mult, input bit fam, input bit wide, input bit run);
    logic [31:0] w = '0;
    w[31] = srst; w[30] = gate; w[29:27] = mult[2:0];
    w[26] = fam;  w[3] = wide;  w[0] = run;
    return w;
  endfunction

  task automatic quiet_window(input int n, input string req, input string what);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk_pulse_o || bclk_pulse_o || lrclk_o) bad++;
    end
    check(bad == 0, req, what, bad, 0);
  endtask

  task automatic sweep_one(input bit fam, input int mult, input bit wide);
    bit legal = !(mult > 4 || (fam && mult == 4));
    int pm = (fam ? 4 : 3) * (1 << mult) * BASE_DIV;
    int pb = (wide ? 32 : 48) * BASE_DIV;
    int bad_m = 0, bad_b = 0, bad_l = 0, bad_e = 0, bad_s = 0, bad_c = 0;
    bit first_ok;
    logic prev_lr = 1'b0;
    string tag = $sformatf("fam=%0d code=%0d wide=%0d", fam, mult, wide);
    @(negedge clk);
    ctrl_word = word(0, 0, mult, fam, wide, 0);
    quiet_window(4, "R7", {"run clear ", tag});
    ctrl_word = word(0, 0, mult, fam, wide, 1);
    for (int k = 1; k <= WIN; k++) begin
      bit em, eb, el;
      @(negedge clk);
      if (legal && k >= 2) begin
        em = ((k - 2) % pm) == 0;
        eb = ((k - 2) % pb) == 0;
        el = ((k - 2) % FRAME) >= FRAME / 2;
      end else begin
        em = 0; eb = 0; el = 0;
      end
      if (k == 2) first_ok = (mclk_pulse_o === em) && (bclk_pulse_o === eb);
      if (mclk_pulse_o !== em) bad_m++;
      if (bclk_pulse_o !== eb) bad_b++;
      if (lrclk_o !== el) bad_l++;
      if (cfg_err_o !== !legal) bad_e++;
      if (k >= 2 && lrclk_o !== prev_lr && !bclk_pulse_o) bad_c++;
      if (k == 1 && (mclk_pulse_o || bclk_pulse_o)) bad_s++;
      prev_lr = lrclk_o;
    end
    if (legal) begin
      check(bad_m == 0, fam ? "R2" : "R1", {"mclk spacing (R3 fields) ", tag}, bad_m, 0);
      check(bad_b == 0, "R4", {"bclk spacing ", tag}, bad_b, 0);
      check(bad_l == 0, "R5", {"lrclk halves ", tag}, bad_l, 0);
      check(first_ok && bad_s == 0, "R6", {"first pulses ", tag}, bad_s, 0);
      check(bad_c == 0, "R10", {"lrclk off bclk ", tag}, bad_c, 0);
    end else begin
      check(bad_m + bad_b + bad_l == 0, "R8", {"illegal code outputs ", tag},
            bad_m + bad_b + bad_l, 0);
    end
    check(bad_e == 0, "R8", {"cfg_err level ", tag}, bad_e, 0);
    ctrl_word = word(0, 0, mult, fam, wide, 0);
    @(negedge clk);
    quiet_window(6, "R7", {"run dropped mid-run ", tag});
  endtask

  task automatic hold_test(input bit srst, input bit gate, input string what);
    @(negedge clk);
    ctrl_word = word(0, 0, 1, 0, 0, 0);
    @(negedge clk);
    ctrl_word = word(srst, gate, 1, 0, 0, 1);
    quiet_window(60, "R7", {what, " from idle"});
    ctrl_word = word(0, 0, 1, 0, 0, 1);
    repeat (100) @(negedge clk);
    ctrl_word = word(srst, gate, 1, 0, 0, 1);
    @(negedge clk);
    quiet_window(60, "R7", {what, " mid-run"});
    ctrl_word = word(0, 0, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl_word = word(0, 0, 1, 0, 0, 1);
    repeat (3) @(negedge clk);
    check(!mclk_pulse_o && !bclk_pulse_o && !lrclk_o && !cfg_err_o, "R9",
          "outputs in reset", {mclk_pulse_o, bclk_pulse_o, lrclk_o, cfg_err_o}, 0);
    ctrl_word = word(0, 0, 1, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mclk_pulse_o && !bclk_pulse_o && !lrclk_o && !cfg_err_o, "R9",
          "outputs after reset", {mclk_pulse_o, bclk_pulse_o, lrclk_o, cfg_err_o}, 0);
    for (int fam = 0; fam < 2; fam++)
      for (int code = 0; code < 8; code++)
        for (int wide = 0; wide < 2; wide++)
          sweep_one(fam[0], code, wide[0]);
    hold_test(0, 1, "clock gate");
    hold_test(1, 0, "soft reset");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule